// File: doc/BRIEF.md
# SERDES Bring-Up Sequencer

This controller takes a multi-channel serial transceiver macro from power-on to a locked link. It acts as a simple master on the macro's register bus: address, write data, write strobe, read strobe, and read data that returns one cycle after the read strobe. It also drives the macro's active-low hardware reset.

While the configuration-done input is low, the sequencer keeps the hardware reset asserted. After release it waits a programmable interval, then writes the bank and channel control registers. The values depend on four mode inputs: loopback, TX half-rate, RX half-rate and the Fibre Channel link state machine. It then pulses the global soft reset and waits the same interval again.

Next it reads all eight per-channel alarm registers once and discards the results, because that first read only clears stale clear-on-read state. After that it polls the PLL-lock bit channel by channel. When all eight channels report lock, it raises a one-cycle start pulse toward the idle-pattern generator and holds a ready flag. If polling runs too long, it flags an error and repeats the sequence from the soft reset.

Top module: `serdes_bringup_seq`

## Requirements
- R1: `hw_reset_n` is low in every cycle that follows a clock edge at which `cfg_done` was low. Whenever `cfg_done` is low, the sequence restarts and `link_ready` drops.
- R2: The first bus access comes exactly `WAIT_CYCLES` cycles after `hw_reset_n` rises. There is no access in between.
- R3: Registers 0x30800 and 0x30900 are written with 0xFF. Bits [3:0] are lock-to-data for channels 0–3, and bits [7:4] are comma-alignment enable.
- R4: Registers 0x30801 and 0x30901 are written with 0x0F when `mode_loopback` is 1, and with 0x00 otherwise.
- R5: Channel c has base 0x30000 + (c[2] ? 0x100 : 0) + c[1:0]·0x10. Its TX register at base+2 is written with bit0 = 1 (8b/10b transmit) and bit1 = `mode_tx_half`, other bits 0.
- R6: Each channel's RX register at base+3 is written with bit0 = 1 (8b/10b receive), bit1 = `mode_rx_half` and bit2 = `mode_fc_link`, other bits 0.
- R7: The soft reset is four writes to 0x30A00 in consecutive cycles, with bit0 = 1, 1, 0, 0 in that order.
- R8: The first alarm read comes exactly `WAIT_CYCLES` cycles after the last soft-reset write. Each alarm register's first read after a soft reset is ignored. Ready requires every alarm register to have been read at least twice since the last soft reset.
- R9: The alarm register of channel c sits at its base address, and the lock bit is bit0. `link_ready` rises only after all eight channels have read lock = 1.
- R10: After `POLL_TIMEOUT` cycles of polling without success, `lock_error` is set and the soft-reset sequence repeats. `lock_error` clears when the link becomes ready.
- R11: `sync_start` is high for exactly one cycle, the first cycle of `link_ready`. `link_ready` then stays high while `cfg_done` stays high.
- R12: If the final lock read and the poll timeout fall in the same cycle, the lock wins: the link becomes ready, there is no error and no extra soft reset.
- R13: The read and write strobes are never high together, and neither is high while `hw_reset_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| cfg_done | input | 1 | Device configuration complete |
| mode_loopback | input | 1 | Request high-speed serial loopback |
| mode_tx_half | input | 1 | Request TX half-rate |
| mode_rx_half | input | 1 | Request RX half-rate |
| mode_fc_link | input | 1 | Enable Fibre Channel link state machine |
| bus_rdata | input | DATA_W | Read data, valid the cycle after `bus_re` |
| hw_reset_n | output | 1 | Active-low hardware reset to the macro |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Register write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| sync_start | output | 1 | One-cycle start pulse for link synchronization |
| link_ready | output | 1 | All PLLs locked; link bring-up done |
| lock_error | output | 1 | Lock poll timed out |

## Verification
The poll timeout and the successful read of the last channel's lock bit can land in the same cycle. A second instance provokes this by setting its timeout to exactly the length of one full polling pass, with all locks already present. The outcome is judged at the ports and on the register traffic. The link must become ready with `lock_error` low, and only one four-write soft-reset run may appear, since a timeout would have launched a second run. The main instance sweeps all sixteen mode combinations, checks every written register value against arithmetic expectations, and separately forces a genuine timeout by withholding one channel's lock.

// File: rtl/serdes_bringup_seq.sv
module serdes_bringup_seq #(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 8,
  parameter int WAIT_CYCLES  = 600000,
  parameter int POLL_TIMEOUT = 65536,
  parameter int LOCK_BIT     = 0,
  parameter logic [19:0] SRST_ADDR = 20'h30A00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_done,
  input  logic              mode_loopback,
  input  logic              mode_tx_half,
  input  logic              mode_rx_half,
  input  logic              mode_fc_link,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              hw_reset_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  output logic              sync_start,
  output logic              link_ready,
  output logic              lock_error
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam int TW = $clog2(POLL_TIMEOUT + 1);
  localparam int NCFG = 20;
  localparam int NCH  = 8;

  typedef enum logic [2:0] {
    S_HOLD, S_PWAIT, S_CFG, S_SRST, S_SWAIT, S_CLR, S_POLL, S_DONE
  } st_t;

  st_t           state;
  logic [CW-1:0] wcnt;
  logic [TW-1:0] tcnt;
  logic [4:0]    idx;
  logic          ph;
  logic          sync_q;
  logic          err_q;

  wire       last_wait = (wcnt == CW'(WAIT_CYCLES - 1));
  wire       timeout   = (tcnt == TW'(POLL_TIMEOUT - 1));
  wire [2:0] ch        = idx[2:0];
  wire [2:0] cfg_ch    = idx[2:0] - 3'd4;
  wire       lock_seen = bus_rdata[LOCK_BIT];
  wire       last_ch   = (idx == 5'(NCH - 1));
  wire       all_lock  = ph && lock_seen && last_ch;

  function automatic logic [ADDR_W-1:0] chan_base(input logic [2:0] c);
    return ADDR_W'(20'h30000) + ADDR_W'({c[2], 8'h00}) + ADDR_W'({c[1:0], 4'h0});
  endfunction

  assign hw_reset_n = (state != S_HOLD);
  assign link_ready = (state == S_DONE);
  assign sync_start = sync_q;
  assign lock_error = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_HOLD;
      wcnt   <= '0;
      tcnt   <= '0;
      idx    <= '0;
      ph     <= 1'b0;
      sync_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      sync_q <= 1'b0;
      if (!cfg_done) begin
        state <= S_HOLD;
        wcnt  <= '0;
        tcnt  <= '0;
        idx   <= '0;
        ph    <= 1'b0;
      end else begin
        case (state)
          S_HOLD: begin
            state <= S_PWAIT;
            wcnt  <= '0;
          end
          S_PWAIT: begin
            if (last_wait) begin
              state <= S_CFG;
              idx   <= '0;
              wcnt  <= '0;
            end else wcnt <= wcnt + 1'b1;
          end
          S_CFG: begin
            if (idx == 5'(NCFG - 1)) begin
              state <= S_SRST;
              idx   <= '0;
            end else idx <= idx + 1'b1;
          end
          S_SRST: begin
            if (idx == 5'd3) begin
              state <= S_SWAIT;
              idx   <= '0;
              wcnt  <= '0;
            end else idx <= idx + 1'b1;
          end
          S_SWAIT: begin
            if (last_wait) begin
              state <= S_CLR;
              idx   <= '0;
              ph    <= 1'b0;
              wcnt  <= '0;
            end else wcnt <= wcnt + 1'b1;
          end
          S_CLR: begin
            ph <= !ph;
            if (ph) begin
              if (last_ch) begin
                state <= S_POLL;
                idx   <= '0;
                tcnt  <= '0;
              end else idx <= idx + 1'b1;
            end
          end
          S_POLL: begin
            tcnt <= tcnt + 1'b1;
            ph   <= !ph;
            if (all_lock) begin
              state  <= S_DONE;
              sync_q <= 1'b1;
              err_q  <= 1'b0;
            end else if (ph && lock_seen) begin
              idx <= idx + 1'b1;
            end
            if (timeout && !all_lock) begin
              state <= S_SRST;
              idx   <= '0;
              ph    <= 1'b0;
              err_q <= 1'b1;
            end
          end
          default: state <= S_DONE;
        endcase
      end
    end
  end

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    case (state)
      S_CFG: begin
        bus_we = 1'b1;
        if (idx < 5'd2) begin
          bus_addr  = idx[0] ? ADDR_W'(20'h30900) : ADDR_W'(20'h30800);
          bus_wdata = DATA_W'(8'hFF);
        end else if (idx < 5'd4) begin
          bus_addr  = idx[0] ? ADDR_W'(20'h30901) : ADDR_W'(20'h30801);
          bus_wdata = mode_loopback ? DATA_W'(8'h0F) : '0;
        end else if (idx < 5'd12) begin
          bus_addr  = chan_base(cfg_ch) + ADDR_W'(2);
          bus_wdata = DATA_W'({mode_tx_half, 1'b1});
        end else begin
          bus_addr  = chan_base(cfg_ch) + ADDR_W'(3);
          bus_wdata = DATA_W'({mode_fc_link, mode_rx_half, 1'b1});
        end
      end
      S_SRST: begin
        bus_we    = 1'b1;
        bus_addr  = ADDR_W'(SRST_ADDR);
        bus_wdata = DATA_W'(idx < 5'd2);
      end
      S_CLR, S_POLL: begin
        bus_re   = !ph;
        bus_addr = chan_base(ch);
      end
      default: ;
    endcase
  end

  wire srst_wr1 = bus_we && (bus_addr == ADDR_W'(SRST_ADDR)) && bus_wdata[0];
  wire srst_wr0 = bus_we && (bus_addr == ADDR_W'(SRST_ADDR)) && !bus_wdata[0];

  p_rst_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_done) |-> (!hw_reset_n && !link_ready));

  p_srst_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_wr1 && !$past(srst_wr1)) |=> (srst_wr1 || !$past(cfg_done)));

  p_srst_first0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_wr1 && $past(srst_wr1)) |=> (srst_wr0 || !$past(cfg_done)));

  p_srst_zeros_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_wr0 && $past(srst_wr1)) |=> (srst_wr0 || !$past(cfg_done)));

  p_lock_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> $past(bus_rdata[LOCK_BIT]));

  p_sync_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> sync_start);

  p_sync_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_start |=> !sync_start);

  p_ready_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ready && cfg_done) |=> link_ready);

  p_bus_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re) && (!(bus_we || bus_re) || hw_reset_n));
endmodule

// File: tb/serdes_bringup_seq_test.sv
`timescale 1ns/1ps
module serdes_bringup_seq_model (
  input  logic       clk,
  input  logic       clr,
  input  logic       hw_reset_n,
  input  logic [19:0] addr,
  input  logic [7:0] wdata,
  input  logic       we,
  input  logic       re,
  input  logic [7:0] lock,
  output logic [7:0] rdata
);
  logic [7:0] mem [0:4095];
  int  since_rise, since_srst, first_gap, srst_gap, srst_total, run_len;
  logic [3:0] run_bits;
  logic seen_first, seen_rd, prev_srst;
  logic [7:0] stale;
  int  rdcnt [0:7];

  wire srst_wr = we && addr == 20'h30A00;
  wire is_alarm = addr[19:12] == 8'h30 && addr[11:9] == 3'd0 && addr[7:6] == 2'd0 && addr[3:0] == 4'd0;
  wire [2:0] ach = {addr[8], addr[5:4]};

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'hEE;
      for (int i = 0; i < 8; i++) rdcnt[i] <= 0;
      since_rise <= 0; since_srst <= 0; first_gap <= -1; srst_gap <= -1;
      srst_total <= 0; run_len <= 0; run_bits <= 4'd0;
      seen_first <= 1'b0; seen_rd <= 1'b0; prev_srst <= 1'b0;
      stale <= 8'hFF; rdata <= 8'h00;
    end else begin
      since_rise <= hw_reset_n ? since_rise + 1 : 0;
      if ((we || re) && hw_reset_n && !seen_first) begin
        first_gap <= since_rise; seen_first <= 1'b1;
      end
      prev_srst <= srst_wr;
      if (srst_wr) begin
        since_srst <= 0; srst_total <= srst_total + 1; stale <= 8'hFF; seen_rd <= 1'b0;
        for (int i = 0; i < 8; i++) rdcnt[i] <= 0;
        if (prev_srst) begin
          run_bits <= {run_bits[2:0], wdata[0]}; run_len <= run_len + 1;
        end else begin
          run_bits <= {3'd0, wdata[0]}; run_len <= 1;
        end
      end else since_srst <= since_srst + 1;
      if (we && !srst_wr) mem[addr[11:0]] <= wdata;
      if (re) begin
        if (is_alarm) begin
          if (!seen_rd) begin srst_gap <= since_srst; seen_rd <= 1'b1; end
          rdcnt[ach] <= rdcnt[ach] + 1;
          rdata <= stale[ach] ? 8'hFF : {7'd0, lock[ach]};
          stale[ach] <= 1'b0;
        end else rdata <= 8'h00;
      end
    end
  end
endmodule

module serdes_bringup_seq_test;
  localparam int WAITC = 50;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_done, lb, txh, rxh, fc, clr;
  logic [7:0] lock_main;
  logic [19:0] a1, a2;
  logic [7:0] wd1, wd2, rd1, rd2;
  logic we1, we2, re1, re2, hr1, hr2, ss1, ss2, rdy1, rdy2, er1, er2;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  serdes_bringup_seq #(.WAIT_CYCLES(WAITC), .POLL_TIMEOUT(200)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .mode_loopback(lb), .mode_tx_half(txh),
    .mode_rx_half(rxh), .mode_fc_link(fc), .bus_rdata(rd1), .hw_reset_n(hr1), .bus_addr(a1),
    .bus_wdata(wd1), .bus_we(we1), .bus_re(re1), .sync_start(ss1), .link_ready(rdy1), .lock_error(er1));
  serdes_bringup_seq_model mdl (.clk(clk), .clr(clr), .hw_reset_n(hr1), .addr(a1), .wdata(wd1),
    .we(we1), .re(re1), .lock(lock_main), .rdata(rd1));

  serdes_bringup_seq #(.WAIT_CYCLES(WAITC), .POLL_TIMEOUT(16)) uut_edge (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .mode_loopback(lb), .mode_tx_half(txh),
    .mode_rx_half(rxh), .mode_fc_link(fc), .bus_rdata(rd2), .hw_reset_n(hr2), .bus_addr(a2),
    .bus_wdata(wd2), .bus_we(we2), .bus_re(re2), .sync_start(ss2), .link_ready(rdy2), .lock_error(er2));
  serdes_bringup_seq_model mdl_edge (.clk(clk), .clr(clr), .hw_reset_n(hr2), .addr(a2), .wdata(wd2),
    .we(we2), .re(re2), .lock(8'hFF), .rdata(rd2));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ready(input bit edge_inst, output bit got);
    got = 0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      got = edge_inst ? rdy2 : rdy1;
    end
  endtask

  task automatic restart();
    rst_n = 1'b0; clr = 1'b1; cfg_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; clr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    lb = 0; txh = 0; rxh = 0; fc = 0; lock_main = 8'hFF;
    restart();
    @(negedge clk);
    chk(!hr1 && !rdy1 && !ss1 && !we1 && !re1 && !er1, "R1 reset state", {hr1, rdy1, ss1, we1, re1, er1}, 0);

    for (int m = 0; m < 16; m++) begin
      lb = m[0]; txh = m[1]; rxh = m[2]; fc = m[3];
      restart();
      repeat (8) @(negedge clk);
      chk(!hr1, "R1 held while cfg_done low", hr1, 0);
      cfg_done = 1'b1;
      wait_ready(0, got);
      chk(got, "R9 main ready", got, 1);
      chk(ss1 == 1'b1, "R11 sync pulse with ready", ss1, 1);
      @(negedge clk);
      chk(ss1 == 1'b0 && rdy1, "R11 single pulse, ready held", {ss1, rdy1}, 1);
      chk(!er1, "R10 no error", er1, 0);
      chk(mdl.first_gap == WAITC, "R2 first access delay", mdl.first_gap, WAITC);
      chk(mdl.mem['h800] == 8'hFF && mdl.mem['h900] == 8'hFF, "R3 bank control",
          {mdl.mem['h800], mdl.mem['h900]}, 16'hFFFF);
      chk(mdl.mem['h801] == (lb ? 8'h0F : 8'h00) && mdl.mem['h901] == (lb ? 8'h0F : 8'h00),
          "R4 loopback", {mdl.mem['h801], mdl.mem['h901]}, lb ? 16'h0F0F : 16'h0);
      for (int c = 0; c < 8; c++) begin
        int off;
        off = (c / 4) * 256 + (c % 4) * 16;
        chk(mdl.mem[off + 2] == {6'd0, txh, 1'b1}, "R5 TX control", mdl.mem[off + 2], {6'd0, txh, 1'b1});
        chk(mdl.mem[off + 3] == {5'd0, fc, rxh, 1'b1}, "R6 RX control", mdl.mem[off + 3], {5'd0, fc, rxh, 1'b1});
        chk(mdl.rdcnt[c] >= 2, "R8 two reads per alarm", mdl.rdcnt[c], 2);
      end
      chk(mdl.run_len == 4 && mdl.run_bits == 4'b1100, "R7 soft reset pattern",
          {mdl.run_len[3:0], mdl.run_bits}, 8'h4C);
      chk(mdl.srst_gap == WAITC, "R8 wait after soft reset", mdl.srst_gap, WAITC);
      wait_ready(1, got);
      chk(got && !er2, "R12 lock wins over timeout", {got, er2}, 2);
      chk(mdl_edge.srst_total == 4, "R12 no retry", mdl_edge.srst_total, 4);
    end

    lb = 0; txh = 0; rxh = 0; fc = 0; lock_main = 8'hF7;
    restart();
    cfg_done = 1'b1;
    repeat (1500) @(negedge clk);
    chk(er1, "R10 timeout flag", er1, 1);
    chk(!rdy1, "R9 R8 not ready with channel 3 unlocked", rdy1, 0);
    chk(mdl.srst_total >= 8, "R10 soft reset repeated", mdl.srst_total, 8);
    chk(mdl.run_len == 4 && mdl.run_bits == 4'b1100, "R7 retry pattern", mdl.run_bits, 4'b1100);
    lock_main = 8'hFF;
    wait_ready(0, got);
    chk(got && !er1, "R10 error clears on ready", {got, er1}, 2);

    @(negedge clk);
    cfg_done = 1'b0;
    @(negedge clk);
    chk(!hr1 && !rdy1, "R1 config drop resets", {hr1, rdy1}, 0);
    chk(!we1 && !re1, "R13 no access in reset", {we1, re1}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule